// File: doc/BRIEF.md
# Frame and IO Interrupt Sequencer

This block sequences interrupts for a small 8-bit processor that has two interrupt sources: a periodic frame tick (source 0) and an external IO request (source 1). It holds the interrupt-disable flag and an in-handler marker. It latches incoming requests. At an instruction boundary it decides whether an interrupt is taken, and it then supplies the addresses of the two bytes that hold the handler's start address.

In the cycle an interrupt is taken, the block also tells the processor to push the 16-bit address of the next instruction. It implements the wait state of the HALT instruction, holding the processor stalled until a frame tick arrives.

The processor reports instruction boundaries and single-cycle strobes for the four decoded control instructions:
- set-disable;
- clear-disable;
- return-from-interrupt;
- halt.

A strobe that arrives together with a boundary belongs to the instruction that retires in that cycle. The take decision uses the flag value as that instruction leaves it. The stack memory and the program-counter datapath sit outside the block.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the disable flag is 1, the in-handler marker is 0, the stall output is 0 and no interrupt is taken.
- R2: While the disable flag is 1 (after the current instruction's update), no interrupt is taken at a boundary. Requests that arrive in that time stay pending.
- R3: When the flag is 0 and a request is pending, a boundary asserts take and push in the same cycle (combinationally). The push data equals the next-PC input.
- R4: When both sources are pending, the frame source (bit 0) wins. The handler address is read from 0xFF00 for the frame source and from 0xFF02 for the IO source.
- R5: Each request bit is latched until its own interrupt is taken. A new request that arrives in the cycle its source is serviced is latched again.
- R6: The cycle after a take, both the disable flag and the in-handler marker read 1.
- R7: Set-disable sets the flag. Clear-disable clears the flag outside a handler, and has no effect while the in-handler marker is 1.
- R8: Return-from-interrupt clears both the flag and the in-handler marker. A boundary in the same cycle with a request pending takes the next interrupt at once. A set-disable at a boundary blocks a take in that same cycle.
- R9: A halt strobe sets the stall output from the next cycle. An IO request does not end the wait; it stays pending. A pending frame request with the flag at 0 takes the frame interrupt and drops the stall in the following cycle.
- R10: A halt entered with the flag at 1 never ends: the stall output stays 1 and no take occurs, whatever requests arrive.
- R11: The high-byte address output equals the low-byte address output plus one (the handler address is stored low byte first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 2 | Request pulses; bit 0 frame tick, bit 1 IO |
| boundary_i | input | 1 | Instruction boundary: an interrupt may be taken now |
| op_sif_i | input | 1 | Decoded set-disable strobe |
| op_cif_i | input | 1 | Decoded clear-disable strobe |
| op_iret_i | input | 1 | Decoded return-from-interrupt strobe |
| op_halt_i | input | 1 | Decoded halt strobe |
| next_pc_i | input | 16 | Address of the next instruction |
| take_o | output | 1 | An interrupt is taken in this cycle |
| vec_lo_addr_o | output | 16 | Address of the handler address low byte (valid with take) |
| vec_hi_addr_o | output | 16 | Address of the handler address high byte (valid with take) |
| push_o | output | 1 | Push the return address this cycle |
| push_pc_o | output | 16 | Return address to push |
| stall_o | output | 1 | Processor held in the halt wait state |
| irq_disable_o | output | 1 | Current interrupt-disable flag |
| in_handler_o | output | 1 | Currently inside an interrupt handler |

## Verification
The return-from-interrupt strobe and a new take can fall in the same cycle. The same holds for a set-disable strobe and a boundary that has a request pending. In each case the flag change and the take decision must resolve within one cycle.

The bench provokes both cases:
- It leaves an IO request pending behind a frame handler, then retires the return instruction on a boundary.
- It issues set-disable on a boundary while a request is latched.

A cycle-accurate reference model judges every cycle. It expects an immediate take of the IO handler at 0xFF02 in the first case and no take in the second. The same check covers a request that repeats in the very cycle its source is serviced.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_WAIT = 1'b1
   } run_st_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic held;
      always_ff @(posedge clk) begin
         if (!rst_n)         held <= 1'b0;
         else if (req_i[g])  held <= 1'b1;
         else if (clr_i[g])  held <= 1'b0;
      end
      assign pend_o[g] = held;
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned SRC_W   = 1
) (
   input  logic [NUM_SRC-1:0] pend_i,
   output logic               any_o,
   output logic [SRC_W-1:0]   idx_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            any_o = 1'b1;
            idx_o = SRC_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_state_ctl.sv
module irq_state_ctl
   import irq_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic op_sif_i,
   input  logic op_cif_i,
   input  logic op_iret_i,
   input  logic op_halt_i,
   input  logic take_i,
   output logic flag_o,
   output logic eff_flag_o,
   output logic in_handler_o,
   output logic waiting_o
);

   logic    flag_q;
   logic    inh_q;
   run_st_e st_q;

   always_comb begin
      eff_flag_o = flag_q;
      if (op_iret_i)                eff_flag_o = 1'b0;
      else if (op_sif_i)            eff_flag_o = 1'b1;
      else if (op_cif_i && !inh_q)  eff_flag_o = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b1;
         inh_q  <= 1'b0;
         st_q   <= ST_RUN;
      end else begin
         flag_q <= take_i ? 1'b1 : eff_flag_o;
         if (take_i)         inh_q <= 1'b1;
         else if (op_iret_i) inh_q <= 1'b0;
         if (take_i)         st_q <= ST_RUN;
         else if (op_halt_i) st_q <= ST_WAIT;
      end
   end

   assign flag_o       = flag_q;
   assign in_handler_o = inh_q;
   assign waiting_o    = (st_q == ST_WAIT);

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
   import irq_seq_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 2,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_BASE   = 16'hFF00,
   parameter int unsigned VEC_STRIDE = 2,
   parameter int unsigned WAKE_SRC   = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req_i,
   input  logic               boundary_i,
   input  logic               op_sif_i,
   input  logic               op_cif_i,
   input  logic               op_iret_i,
   input  logic               op_halt_i,
   input  logic [ADDR_W-1:0]  next_pc_i,
   output logic               take_o,
   output logic [ADDR_W-1:0]  vec_lo_addr_o,
   output logic [ADDR_W-1:0]  vec_hi_addr_o,
   output logic               push_o,
   output logic [ADDR_W-1:0]  push_pc_o,
   output logic               stall_o,
   output logic               irq_disable_o,
   output logic               in_handler_o
);

   localparam int unsigned SRC_W = idx_width(NUM_SRC);

   if (NUM_SRC < 1) begin : g_bad_num
      $error("NUM_SRC must be at least 1");
   end
   if (WAKE_SRC >= NUM_SRC) begin : g_bad_wake
      $error("WAKE_SRC must name an existing source");
   end
   if (VEC_STRIDE < 2) begin : g_bad_stride
      $error("VEC_STRIDE must leave room for a two-byte address");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] clr;
   logic [NUM_SRC-1:0] cand;
   logic               any;
   logic [SRC_W-1:0]   idx;
   logic               flag;
   logic               eff_flag;
   logic               inh;
   logic               waiting;
   logic               take;

   irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (irq_req_i),
      .clr_i  (clr),
      .pend_o (pend)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
      if (g == WAKE_SRC) begin : g_wake
         assign cand[g] = pend[g];
      end else begin : g_other
         assign cand[g] = pend[g] && !waiting;
      end
      assign clr[g] = take && (idx == SRC_W'(g));
   end

   irq_prio_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pick (
      .pend_i (cand),
      .any_o  (any),
      .idx_o  (idx)
   );

   irq_state_ctl u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_sif_i     (op_sif_i),
      .op_cif_i     (op_cif_i),
      .op_iret_i    (op_iret_i),
      .op_halt_i    (op_halt_i),
      .take_i       (take),
      .flag_o       (flag),
      .eff_flag_o   (eff_flag),
      .in_handler_o (inh),
      .waiting_o    (waiting)
   );

   always_comb begin
      if (waiting) take = any && !flag;
      else         take = boundary_i && !op_halt_i && !eff_flag && any;
   end

   assign vec_lo_addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(idx) * ADDR_W'(VEC_STRIDE);
   assign vec_hi_addr_o = vec_lo_addr_o + ADDR_W'(1);
   assign take_o        = take;
   assign push_o        = take;
   assign push_pc_o     = next_pc_i;
   assign stall_o       = waiting;
   assign irq_disable_o = flag;
   assign in_handler_o  = inh;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              take_o,
   input logic              stall_o,
   input logic              irq_disable_o,
   input logic              in_handler_o,
   input logic              op_iret_i,
   input logic              op_cif_i,
   input logic [ADDR_W-1:0] vec_lo_addr_o,
   input logic [ADDR_W-1:0] vec_hi_addr_o
);

   // R2
   take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && irq_disable_o) |-> (op_iret_i || (op_cif_i && !in_handler_o)));

   // R6
   take_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (irq_disable_o && in_handler_o));

   // R8
   iret_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_iret_i && !take_o) |=> (!irq_disable_o && !in_handler_o));

   // R9
   stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && !take_o) |=> stall_o);

   // R10
   dead_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && irq_disable_o) |-> !take_o);

   // R11
   vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (vec_hi_addr_o == vec_lo_addr_o + ADDR_W'(1)));

endmodule

bind irq_seq_top irq_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .take_o        (take_o),
   .stall_o       (stall_o),
   .irq_disable_o (irq_disable_o),
   .in_handler_o  (in_handler_o),
   .op_iret_i     (op_iret_i),
   .op_cif_i      (op_cif_i),
   .vec_lo_addr_o (vec_lo_addr_o),
   .vec_hi_addr_o (vec_hi_addr_o)
);

// File: tb/tb_irq_seq_top.sv
`timescale 1ns/100ps
module tb_irq_seq_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  irq_req_i = '0;
   logic        boundary_i = 1'b0;
   logic        op_sif_i = 1'b0, op_cif_i = 1'b0, op_iret_i = 1'b0, op_halt_i = 1'b0;
   logic [15:0] next_pc_i = '0;
   logic        take_o, push_o, stall_o, irq_disable_o, in_handler_o;
   logic [15:0] vec_lo_addr_o, vec_hi_addr_o, push_pc_o;

   always #2 clk = ~clk;

   irq_seq_top dut (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .boundary_i(boundary_i),
      .op_sif_i(op_sif_i), .op_cif_i(op_cif_i), .op_iret_i(op_iret_i),
      .op_halt_i(op_halt_i), .next_pc_i(next_pc_i), .take_o(take_o),
      .vec_lo_addr_o(vec_lo_addr_o), .vec_hi_addr_o(vec_hi_addr_o),
      .push_o(push_o), .push_pc_o(push_pc_o), .stall_o(stall_o),
      .irq_disable_o(irq_disable_o), .in_handler_o(in_handler_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model state
   int m_pend[2];
   int m_flag, m_inh, m_wait;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pend[0] = 0; m_pend[1] = 0;
      m_flag = 1; m_inh = 0; m_wait = 0;
   endtask

   task automatic step(input logic [1:0] req, input logic bnd, input logic sif,
                       input logic cif, input logic iret, input logic hlt,
                       input logic [15:0] npc, input string tag);
      int eff, tk, sel;
      @(negedge clk);
      irq_req_i = req; boundary_i = bnd; op_sif_i = sif; op_cif_i = cif;
      op_iret_i = iret; op_halt_i = hlt; next_pc_i = npc;
      eff = m_flag;
      if (iret) eff = 0;
      else if (sif) eff = 1;
      else if (cif && m_inh == 0) eff = 0;
      sel = 0; tk = 0;
      if (m_wait != 0) begin
         tk = (m_pend[0] != 0 && m_flag == 0) ? 1 : 0;
      end else if (bnd && !hlt && eff == 0 && (m_pend[0] != 0 || m_pend[1] != 0)) begin
         tk = 1;
         sel = (m_pend[0] != 0) ? 0 : 1;
      end
      #1;
      chk(tag, "take", int'(take_o), tk);
      chk(tag, "push", int'(push_o), tk);
      chk(tag, "stall", int'(stall_o), m_wait);
      chk(tag, "flag", int'(irq_disable_o), m_flag);
      chk(tag, "in_handler", int'(in_handler_o), m_inh);
      if (tk != 0) begin
         chk({tag, " R4"}, "vec_lo", int'(vec_lo_addr_o), 16'hFF00 + 2 * sel);
         chk({tag, " R11"}, "vec_hi", int'(vec_hi_addr_o), 16'hFF01 + 2 * sel);
         chk({tag, " R3"}, "push_pc", int'(push_pc_o), int'(npc));
      end
      @(posedge clk);
      if (tk != 0) begin
         m_pend[sel] = 0;
         m_flag = 1; m_inh = 1; m_wait = 0;
      end else begin
         m_flag = eff;
         if (iret) m_inh = 0;
         if (hlt) m_wait = 1;
      end
      if (req[0]) m_pend[0] = 1;
      if (req[1]) m_pend[1] = 1;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(2'b00, 1'b0, 0, 0, 0, 0, 16'h0000, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      irq_req_i = '0; boundary_i = 0; op_sif_i = 0; op_cif_i = 0;
      op_iret_i = 0; op_halt_i = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      idle(2, "R1");
      // requests while disabled
      step(2'b11, 1'b1, 0, 0, 0, 0, 16'h0100, "R2");
      step(2'b00, 1'b1, 0, 0, 0, 0, 16'h0102, "R2");
      // clear-disable at boundary: frame taken at once
      step(2'b00, 1'b1, 0, 1, 0, 0, 16'h0104, "R7");
      idle(1, "R6");
      // clear-disable inside handler is ignored
      step(2'b00, 1'b1, 0, 1, 0, 0, 16'h2000, "R7");
      idle(1, "R7");
      // return on a boundary with IO pending: immediate take
      step(2'b00, 1'b1, 0, 0, 1, 0, 16'h0104, "R8");
      step(2'b00, 1'b0, 0, 0, 1, 0, 16'h3000, "R8");
      idle(1, "R8");
      step(2'b00, 1'b1, 0, 0, 0, 0, 16'h0110, "R3");
      // both pending: frame first, IO kept
      step(2'b10, 1'b0, 0, 0, 0, 0, 16'h0110, "R4");
      step(2'b01, 1'b0, 0, 0, 0, 0, 16'h0110, "R4");
      step(2'b00, 1'b1, 0, 0, 0, 0, 16'h0112, "R4");
      step(2'b00, 1'b0, 0, 0, 1, 0, 16'h2004, "R5");
      step(2'b00, 1'b1, 0, 0, 0, 0, 16'h0114, "R5");
      step(2'b00, 1'b0, 0, 0, 1, 0, 16'h3004, "R5");
      // repeat in the servicing cycle is latched again
      step(2'b01, 1'b0, 0, 0, 0, 0, 16'h0120, "R5");
      step(2'b01, 1'b1, 0, 0, 0, 0, 16'h0122, "R5");
      step(2'b00, 1'b0, 0, 0, 1, 0, 16'h2008, "R5");
      step(2'b00, 1'b1, 0, 0, 0, 0, 16'h0124, "R5");
      step(2'b00, 1'b0, 0, 0, 1, 0, 16'h200A, "R5");
      // set-disable on a boundary blocks the take
      step(2'b10, 1'b0, 0, 0, 0, 0, 16'h0130, "R8");
      step(2'b00, 1'b1, 1, 0, 0, 0, 16'h0132, "R8");
      step(2'b00, 1'b1, 0, 0, 0, 0, 16'h0134, "R2");
      step(2'b00, 1'b0, 0, 1, 0, 0, 16'h0136, "R7");
      step(2'b00, 1'b1, 0, 0, 0, 0, 16'h0138, "R3");
      step(2'b00, 1'b0, 0, 0, 1, 0, 16'h300C, "R8");
      // halt: IO does not wake, frame does
      step(2'b00, 1'b1, 0, 0, 0, 1, 16'h0140, "R9");
      step(2'b10, 1'b0, 0, 0, 0, 0, 16'h0142, "R9");
      idle(4, "R9");
      step(2'b01, 1'b0, 0, 0, 0, 0, 16'h0142, "R9");
      step(2'b00, 1'b0, 0, 0, 0, 0, 16'h0142, "R9");
      idle(1, "R9");
      step(2'b00, 1'b1, 0, 0, 1, 0, 16'h0142, "R9");
      step(2'b00, 1'b0, 0, 0, 1, 0, 16'h300E, "R9");
      // halt with the flag set never ends
      step(2'b00, 1'b0, 1, 0, 0, 0, 16'h0150, "R10");
      step(2'b00, 1'b1, 0, 0, 0, 1, 16'h0152, "R10");
      step(2'b01, 1'b0, 0, 0, 0, 0, 16'h0154, "R10");
      step(2'b10, 1'b0, 0, 0, 0, 0, 16'h0154, "R10");
      idle(12, "R10");
      do_reset();
      idle(2, "R1");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule